// File: doc/BRIEF.md
# Residue-Parallel Modular Arithmetic Unit

This block adds or multiplies two numbers held as residue vectors. Each vector has six residues: four primary lanes with moduli 199, 233, 194 and 239, and two check lanes with moduli 251 and 509. Every lane computes its own modular result and has no link to any other lane. The check lanes run the same operation as the primary lanes. A later consistency check can therefore catch a fault in the arithmetic itself, as well as a fault in stored data.

The unit accepts one operation per cycle through a valid/ready handshake. The result appears two cycles after acceptance and is held while the consumer stalls. If any operand residue is not below its lane modulus, the result carries a range-error flag, and the residue values for that transaction are undefined.

The pipeline is driven by a four-state control machine:
- ST_EMPTY: both stages are empty.
- ST_FIRST: only stage 1 is full.
- ST_LAST: only stage 2 (the output) is full.
- ST_BOTH: both stages are full.

The machine changes state only on a cycle where the pipe can advance. That happens when stage 2 is empty or the consumer is ready.

| From | Input accepted | Next state |
|------|----------------|------------|
| ST_EMPTY | yes | ST_FIRST |
| ST_EMPTY | no | stays ST_EMPTY |
| ST_FIRST | yes | ST_BOTH |
| ST_FIRST | no | ST_LAST |
| ST_LAST | yes | ST_FIRST |
| ST_LAST | no | ST_EMPTY |
| ST_BOTH | yes | stays ST_BOTH |
| ST_BOTH | no | ST_LAST |

While the pipe is blocked the machine holds its state. This only happens in ST_LAST or ST_BOTH with the consumer not ready.

Top module: `rrns_alu`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: With op_mul = 0, each lane i of the result equals (a_i + b_i) mod m_i.
- R3: With op_mul = 1, each lane i of the result equals (a_i * b_i) mod m_i. The reduction uses a fixed reciprocal constant and a single correction step, with no divider.
- R4: The lanes are packed into the operand and result vectors as follows. A lane's result depends only on that lane's operands, with no carry between lanes.

  | Lane | Modulus | Bits |
  |------|---------|------|
  | 0 | 199 | [7:0] |
  | 1 | 233 | [15:8] |
  | 2 | 194 | [23:16] |
  | 3 | 239 | [31:24] |
  | 4 | 251 | [39:32] |
  | 5 | 509 | [48:40] |

- R5: An operation accepted at a clock edge with out_ready held high is presented on the output after the second following edge. A new operation can be accepted every cycle.
- R6: While out_valid is 1 and out_ready is 0, out_valid, out_res and out_range_err remain unchanged.
- R7: out_range_err is 1 for a transaction exactly when some operand residue is greater than or equal to its lane modulus.
- R8: When out_range_err is 0, every output lane residue is below its modulus.
- R9: The corner operands 0, 1 and m_i-1 give exact results. For example, (m-1)+(m-1) gives m-2, and (m-1)*(m-1) gives 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand vectors and op select are valid |
| in_ready | output | 1 | Unit can take an operation this cycle |
| op_mul | input | 1 | 1 = multiply, 0 = add |
| in_a | input | 49 | First operand residue vector |
| in_b | input | 49 | Second operand residue vector |
| out_valid | output | 1 | Result vector is valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_res | output | 49 | Result residue vector |
| out_range_err | output | 1 | An operand residue was not below its modulus |

## Verification
The bench feeds every lane the values 0, 1 and m-1 for both operations. If the add path subtracted the modulus at the wrong threshold, m-1 plus 1 would come out as m instead of 0. If the reciprocal reduction were one correction short, (m-1)*(m-1) would come out as m+1 instead of 1. A directed add that wraps only lane 0 would expose any carry into lane 1. Random traffic with random consumer stalls shows whether a stalled result drifts or a queued operation is lost. Injected out-of-range residues, including 509 in the widest lane, show whether the error flag is missed or attached to the wrong transaction.

// File: rtl/rrns_pkg.sv
package rrns_pkg;

    localparam int NUM_LANES = 6;

    function automatic int lane_mod(input int idx);
        case (idx)
            0:       return 199;
            1:       return 233;
            2:       return 194;
            3:       return 239;
            4:       return 251;
            default: return 509;
        endcase
    endfunction

    function automatic int lane_width(input int idx);
        return $clog2(lane_mod(idx));
    endfunction

    function automatic int lane_lsb(input int idx);
        int s;
        s = 0;
        for (int k = 0; k < idx; k++) s += lane_width(k);
        return s;
    endfunction

    localparam int RES_W = lane_lsb(NUM_LANES);

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FIRST = 2'd1,
        ST_LAST  = 2'd2,
        ST_BOTH  = 2'd3
    } pipe_state_e;

endpackage

// File: rtl/rrns_pipe_ctrl.sv
module rrns_pipe_ctrl
    import rrns_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic adv,
    output logic out_valid
);

    pipe_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (adv) begin
            unique case (state_q)
                ST_EMPTY: state_d = in_valid ? ST_FIRST : ST_EMPTY;
                ST_FIRST: state_d = in_valid ? ST_BOTH  : ST_LAST;
                ST_LAST:  state_d = in_valid ? ST_FIRST : ST_EMPTY;
                ST_BOTH:  state_d = in_valid ? ST_BOTH  : ST_LAST;
                default:  state_d = ST_EMPTY;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_EMPTY: out_valid = 1'b0;
            ST_FIRST: out_valid = 1'b0;
            ST_LAST:  out_valid = 1'b1;
            ST_BOTH:  out_valid = 1'b1;
            default:  out_valid = 1'b0;
        endcase
        adv = !out_valid || out_ready;
    end

    // R6: a full pipe facing a stalled consumer stays full
    assert_full_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOTH && !out_ready) |=> (state_q == ST_BOTH));

endmodule

// File: rtl/rrns_lane.sv
module rrns_lane #(
    parameter int M = 199,
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         op_mul,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         range_err
);

    localparam int PW = 2 * W;
    localparam logic [PW-1:0] MU  = PW'((1 << PW) / M);
    localparam logic [PW-1:0] M_P = PW'(M);
    localparam logic [W:0]    M_S = (W + 1)'(M);
    localparam logic [W-1:0]  M_A = W'(M);

    // stage 1: raw product and sum
    logic [PW-1:0] prod_q;
    logic [W:0]    sum_q;
    logic          mul_q;
    logic          err1_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            sum_q  <= '0;
            mul_q  <= 1'b0;
            err1_q <= 1'b0;
        end else if (en) begin
            prod_q <= {{W{1'b0}}, a} * {{W{1'b0}}, b};
            sum_q  <= {1'b0, a} + {1'b0, b};
            mul_q  <= op_mul;
            err1_q <= (a >= M_A) || (b >= M_A);
        end
    end

    // reciprocal-constant reduction of the product
    logic [2*PW-1:0] pmu;
    logic [PW-1:0]   quo;
    logic [PW-1:0]   qm;
    logic [PW-1:0]   rem_raw;
    logic [PW-1:0]   rem_fix;
    logic [W:0]      sum_fix;
    logic [W-1:0]    red;

    always_comb begin
        pmu     = {{PW{1'b0}}, prod_q} * {{PW{1'b0}}, MU};
        quo     = PW'(pmu >> PW);
        qm      = quo * M_P;
        rem_raw = prod_q - qm;
        rem_fix = (rem_raw >= M_P) ? rem_raw - M_P : rem_raw;
        sum_fix = (sum_q >= M_S) ? sum_q - M_S : sum_q;
        red     = mul_q ? W'(rem_fix) : W'(sum_fix);
    end

    // R3: one correction step is enough for any product of W-bit operands
    assert_barrett_one_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rem_raw < PW'(2 * M));

    // stage 2: reduced result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res       <= '0;
            range_err <= 1'b0;
        end else if (en) begin
            res       <= red;
            range_err <= err1_q;
        end
    end

endmodule

// File: rtl/rrns_alu.sv
module rrns_alu
    import rrns_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             op_mul,
    input  logic [RES_W-1:0] in_a,
    input  logic [RES_W-1:0] in_b,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [RES_W-1:0] out_res,
    output logic             out_range_err
);

    logic adv;
    logic [NUM_LANES-1:0] lane_err;
    logic [NUM_LANES-1:0] in_bad;

    rrns_pipe_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .adv       (adv),
        .out_valid (out_valid)
    );

    assign in_ready = adv;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int LW  = lane_width(g);
        localparam int LSB = lane_lsb(g);
        localparam int MOD = lane_mod(g);

        rrns_lane #(.M(MOD), .W(LW)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (adv),
            .op_mul    (op_mul),
            .a         (in_a[LSB +: LW]),
            .b         (in_b[LSB +: LW]),
            .res       (out_res[LSB +: LW]),
            .range_err (lane_err[g])
        );

        assign in_bad[g] = (in_a[LSB +: LW] >= LW'(MOD)) || (in_b[LSB +: LW] >= LW'(MOD));

        // R8: a result without a range error is fully reduced
        assert_res_below_mod_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !out_range_err) |-> (out_res[LSB +: LW] < LW'(MOD)));
    end

    assign out_range_err = |lane_err;

    // R6: a stalled result does not move
    assert_hold_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_res) && $stable(out_range_err)));

    // R5: an accepted operation leaves the output stage non-empty two edges later
    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> ##1 out_valid);

    // R7: a bad operand that advances into the output stage is flagged
    assert_range_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (|in_bad)) ##1 in_ready |=> out_range_err);

endmodule

// File: tb/test_rrns_alu.sv
`timescale 1ns/1ps
module test_rrns_alu;

    localparam int NL = 6;
    localparam int VW = 49;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic          in_ready;
    logic          op_mul;
    logic [VW-1:0] in_a;
    logic [VW-1:0] in_b;
    logic          out_valid;
    logic          out_ready;
    logic [VW-1:0] out_res;
    logic          out_range_err;

    always #2.5 clk = ~clk;

    rrns_alu i_rrns_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .op_mul(op_mul), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_ready(out_ready), .out_res(out_res), .out_range_err(out_range_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    logic [VW-1:0] q_res[$];
    bit            q_err[$];
    bit            q_mul[$];
    int            q_cyc[$];
    bit            q_lat[$];
    string         q_tag[$];

    bit            was_stalled = 0;
    logic [VW-1:0] held_res;
    bit            held_err;

    function automatic int tmod(input int i);
        int t[NL] = '{199, 233, 194, 239, 251, 509};
        return t[i];
    endfunction
    function automatic int twid(input int i);
        return (i == 5) ? 9 : 8;
    endfunction
    function automatic int tlsb(input int i);
        return 8 * i;
    endfunction
    function automatic int getf(input logic [VW-1:0] v, input int i);
        return int'((v >> tlsb(i)) & ((49'd1 << twid(i)) - 49'd1));
    endfunction
    function automatic logic [VW-1:0] setf(input logic [VW-1:0] v, input int i, input int x);
        logic [VW-1:0] mask;
        mask = ((49'd1 << twid(i)) - 49'd1) << tlsb(i);
        return (v & ~mask) | ((VW'(x) << tlsb(i)) & mask);
    endfunction
    function automatic logic [VW-1:0] model(input bit mul, input logic [VW-1:0] a, input logic [VW-1:0] b);
        logic [VW-1:0] r;
        r = '0;
        for (int i = 0; i < NL; i++) begin
            if (mul) r = setf(r, i, (getf(a, i) * getf(b, i)) % tmod(i));
            else     r = setf(r, i, (getf(a, i) + getf(b, i)) % tmod(i));
        end
        return r;
    endfunction
    function automatic bit bad_in(input logic [VW-1:0] a, input logic [VW-1:0] b);
        bit e;
        e = 0;
        for (int i = 0; i < NL; i++)
            if (getf(a, i) >= tmod(i) || getf(b, i) >= tmod(i)) e = 1;
        return e;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic compare_out();
        logic [VW-1:0] e_res;
        bit            e_err, e_mul, e_lat;
        int            e_cyc;
        string         tag;
        if (q_res.size() == 0) begin
            chk(0, "R5 unexpected output", 1, 0);
            return;
        end
        e_res = q_res.pop_front(); e_err = q_err.pop_front(); e_mul = q_mul.pop_front();
        e_cyc = q_cyc.pop_front(); e_lat = q_lat.pop_front(); tag = q_tag.pop_front();
        chk(out_range_err == e_err, {"R7 range flag ", tag}, int'(out_range_err), int'(e_err));
        if (e_lat) chk(cyc - e_cyc == 2, "R5 latency", cyc - e_cyc, 2);
        if (!e_err) begin
            for (int i = 0; i < NL; i++) begin
                chk(getf(out_res, i) == getf(e_res, i),
                    $sformatf("%s %s lane %0d", e_mul ? "R3" : "R2", tag, i),
                    getf(out_res, i), getf(e_res, i));
                chk(getf(out_res, i) < tmod(i), $sformatf("R8 lane %0d", i),
                    getf(out_res, i), tmod(i) - 1);
            end
        end
    endtask

    task automatic step(input bit iv, input bit mul, input logic [VW-1:0] a,
                        input logic [VW-1:0] b, input bit ordy, input string tag,
                        input bit lat, output bit took);
        @(negedge clk);
        cyc++;
        in_valid = iv; op_mul = mul; in_a = a; in_b = b; out_ready = ordy;
        #1;
        if (was_stalled) begin
            chk(out_valid == 1'b1, "R6 valid held", int'(out_valid), 1);
            chk(out_res == held_res, "R6 result held", int'(out_res[31:0]), int'(held_res[31:0]));
            chk(out_range_err == held_err, "R6 flag held", int'(out_range_err), int'(held_err));
        end
        was_stalled = out_valid && !out_ready;
        held_res = out_res;
        held_err = out_range_err;
        if (out_valid && out_ready) compare_out();
        took = iv && in_ready;
        if (took) begin
            q_res.push_back(model(mul, a, b));
            q_err.push_back(bad_in(a, b));
            q_mul.push_back(mul);
            q_cyc.push_back(cyc);
            q_lat.push_back(lat);
            q_tag.push_back(tag);
        end
    endtask

    task automatic drain();
        bit t;
        for (int k = 0; k < 20 && q_res.size() != 0; k++)
            step(0, 0, '0, '0, 1, "drain", 0, t);
    endtask

    function automatic int pick(input int i, input int sel);
        case (sel)
            0: return 0;
            1: return 1;
            default: return tmod(i) - 1;
        endcase
    endfunction

    initial begin
        bit t;
        logic [VW-1:0] a, b;
        void'($urandom(32'd20150702));
        rst_n = 0; in_valid = 0; op_mul = 0; in_a = '0; in_b = '0; out_ready = 1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

        // R9: every corner pairing, both ops, back-to-back with latency check (R5)
        for (int op = 0; op < 2; op++)
            for (int sa = 0; sa < 3; sa++)
                for (int sb = 0; sb < 3; sb++) begin
                    a = '0; b = '0;
                    for (int i = 0; i < NL; i++) begin
                        a = setf(a, i, pick(i, sa));
                        b = setf(b, i, pick(i, sb));
                    end
                    step(1, op[0], a, b, 1, "R9 corner", 1, t);
                end
        drain();

        // R4: only lane 0 wraps; other lanes must stay zero
        a = setf('0, 0, 198); b = setf('0, 0, 198);
        step(1, 0, a, b, 1, "R4 isolation", 1, t);
        a = setf('0, 3, 238); b = setf('0, 3, 2);
        step(1, 1, a, b, 1, "R4 isolation", 1, t);
        drain();

        // R7: directed out-of-range residues
        a = setf('0, 5, 509);
        step(1, 0, a, '0, 1, "R7 lane5=509", 1, t);
        b = setf('0, 2, 194);
        step(1, 1, '0, b, 1, "R7 lane2=194", 1, t);
        drain();

        // random traffic with stalls and occasional bad residues
        for (int n = 0; n < 3000; n++) begin
            bit mul, bad;
            mul = $urandom_range(0, 1) == 1;
            bad = $urandom_range(0, 99) < 4;
            a = '0; b = '0;
            for (int i = 0; i < NL; i++) begin
                int ra, rb;
                ra = ($urandom_range(0, 9) == 0) ? pick(i, $urandom_range(0, 2)) : $urandom_range(0, tmod(i) - 1);
                rb = ($urandom_range(0, 9) == 0) ? pick(i, $urandom_range(0, 2)) : $urandom_range(0, tmod(i) - 1);
                a = setf(a, i, ra);
                b = setf(b, i, rb);
            end
            if (bad) a = setf(a, $urandom_range(0, NL - 1), 255);
            if ($urandom_range(0, 9) < 3) step(0, 0, '0, '0, $urandom_range(0, 9) < 7, "idle", 0, t);
            t = 0;
            while (!t) step(1, mul, a, b, $urandom_range(0, 9) < 7, "random", 0, t);
        end
        drain();
        chk(q_res.size() == 0, "R5 all results delivered", q_res.size(), 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R5 actual=%0d expected=%0d", cyc, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule